// File: doc/BRIEF.md
# Single-Port Word Memory Responder with Bus-Rule Checking

This block answers a simple valid/ready requester bus that carries one transfer at a time. Each request presents a byte address, write data, a four-bit byte-lane write mask and a flag that marks code fetches. A mask of zero requests a read. Any other mask requests a write in which each mask bit enables one byte of the addressed 32-bit word. The block stores the words in a single-port array. It returns a whole word on reads and an acknowledge on `rsp_ready`.

A parameter selects the acknowledge timing. With `WAIT_CYCLES` at zero, the acknowledge follows the request in the same cycle, so transfers can follow one another every cycle. With a nonzero value, the acknowledge comes a fixed number of cycles after the request opens.

While it serves transfers, the block also polices the requester. It raises sticky flags for three cases: a mask outside the legal aligned set, request fields that move or a request that is withdrawn before the acknowledge, and an address beyond the array. It also reports whether the last completed transfer was a code fetch.

Top module: `bus_word_responder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no request, `rsp_ready`, `rsp_fetch`, `err_strobe`, `err_hold` and `err_range` are all 0.
- R2: With `WAIT_CYCLES` = 0, `rsp_ready` is high in every cycle in which `req_valid` is high, and `rsp_ready` is never high without `req_valid`.
- R3: With `WAIT_CYCLES` = N > 0, a request that opens in cycle k is acknowledged in cycle k+N and in no earlier cycle. `rsp_ready` lasts one cycle.
- R4: A write (nonzero `req_strb`) updates only the bytes whose mask bits are set. Bit i enables bits 8i+7..8i of the word. A read returns the whole word on `rsp_rdata` in the cycle `rsp_ready` is high.
- R5: A read (`req_strb` = 0) leaves the stored word unchanged, whatever is on `req_wdata`.
- R6: The only legal mask values are 0000, 0001, 0010, 0100, 1000, 0011, 1100 and 1111. A completed transfer with any other value sets `err_strobe` one cycle later and does not change memory.
- R7: While a request waits for its acknowledge, the requester must keep `req_valid` high and must keep `req_addr`, `req_wdata`, `req_strb` and `req_fetch` unchanged. A change, or a withdrawal, sets `err_hold` at the next edge.
- R8: The word index is `req_addr` shifted right by 2. A completed transfer whose index is DEPTH or more sets `err_range` one cycle later and writes nothing, and a read of such an index returns 0.
- R9: `err_strobe`, `err_hold` and `err_range` stay set after being raised, and only reset clears them.
- R10: `rsp_fetch` shows, from the cycle after each acknowledge, the `req_fetch` value of that completed transfer.
- R11: With `WAIT_CYCLES` = 0, transfers presented in consecutive cycles each complete in their own cycle with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane write mask, zero for read |
| req_fetch | input | 1 | Request is a code fetch |
| rsp_ready | output | 1 | Acknowledge of the current request |
| rsp_rdata | output | 32 | Read word, valid while `rsp_ready` is high |
| rsp_fetch | output | 1 | Fetch flag of the last completed transfer |
| err_strobe | output | 1 | Sticky: illegal mask seen |
| err_hold | output | 1 | Sticky: request changed or withdrawn while waiting |
| err_range | output | 1 | Sticky: access beyond the array |

## Verification
A wait counter holding the wrong value would move the acknowledge away from cycle k+N. A bench that counts cycles from the opening of a request sees this on the first transfer. A mis-decoded lane enable or a blocked write that still lands would show up as a wrong word on the next read of that address, one transfer later. A broken snapshot or a flag that fails to stay set would show on the error outputs one edge after the offending cycle, or after any later clean transfer.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  localparam int unsigned LANES = 4;

  function automatic logic strb_is_legal(input logic [LANES-1:0] s);
    case (s)
      4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bwr_wait_timer.sv
module bwr_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  output logic ready
);

  generate
    if (WAIT_CYCLES == 0) begin : g_zero
      assign ready = valid;
    end else begin : g_count
      localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign ready = valid && (cnt_q == LIMIT);

      always_comb begin
        cnt_en = 1'b1;
        if (valid && !ready) cnt_d = cnt_q + 1'b1;
        else                 cnt_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assert_single_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    end
  endgenerate

endmodule

// File: rtl/bwr_rule_checker.sv
module bwr_rule_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          ready,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    strb,
  input  logic          fetch,
  input  logic          in_range,
  output logic          strb_ok,
  output logic          err_strobe,
  output logic          err_hold,
  output logic          err_range
);
  import bwr_pkg::*;

  localparam int unsigned SW = AW + DW + 4 + 1;

  logic          pending_q, pending_d;
  logic [SW-1:0] snap_q, snap_d, fields;
  logic          es_d, eh_d, er_d;
  logic          handshake, hold_bad;

  assign fields    = {addr, wdata, strb, fetch};
  assign handshake = valid && ready;
  assign strb_ok   = strb_is_legal(strb);
  assign hold_bad  = pending_q && (!valid || (fields != snap_q));

  always_comb begin
    pending_d = valid && !ready;
    snap_d    = pending_d ? fields : snap_q;
    es_d      = err_strobe || (handshake && !strb_ok);
    eh_d      = err_hold || hold_bad;
    er_d      = err_range || (handshake && !in_range);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      snap_q     <= '0;
      err_strobe <= 1'b0;
      err_hold   <= 1'b0;
      err_range  <= 1'b0;
    end else begin
      pending_q  <= pending_d;
      snap_q     <= snap_d;
      err_strobe <= es_d;
      err_hold   <= eh_d;
      err_range  <= er_d;
    end
  end

  assert_illegal_strb_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !strb_is_legal(strb)) |=> err_strobe);
  assert_hold_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !valid) |=> err_hold);
  assert_strobe_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_strobe |=> err_strobe);
  assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_hold |=> err_hold);
  assert_range_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |=> err_range);

endmodule

// File: rtl/bwr_word_store.sv
module bwr_word_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [3:0]    wr_strb,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);

  generate
    for (genvar l = 0; l < 4; l++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];
      logic       lane_we;

      assign lane_we = wr_en && wr_strb[l];

      always_ff @(posedge clk) begin
        if (lane_we) lane_mem[wr_idx] <= wr_data[l*8 +: 8];
      end

      assign rd_data[l*8 +: 8] = lane_mem[rd_idx];
    end
  endgenerate

endmodule

// File: rtl/bus_word_responder.sv
module bus_word_responder #(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned WAIT_CYCLES = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  input  logic        req_fetch,
  output logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_fetch,
  output logic        err_strobe,
  output logic        err_hold,
  output logic        err_range
);

  localparam int unsigned AW  = 32;
  localparam int unsigned XW  = AW - 2;
  localparam int unsigned IW  = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH);

  logic [XW-1:0] word_idx;
  logic          in_range, handshake, strb_ok, wr_en;
  logic [31:0]   store_rd;
  logic          fetch_d;

  assign word_idx  = req_addr[AW-1:2];
  assign in_range  = word_idx < DEPTH_X;
  assign handshake = req_valid && rsp_ready;
  assign wr_en     = handshake && (req_strb != 4'b0000) && strb_ok && in_range;
  assign rsp_rdata = in_range ? store_rd : 32'h0;

  bwr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (req_valid),
    .ready (rsp_ready)
  );

  bwr_rule_checker #(.AW(AW), .DW(32)) u_rules (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (req_valid),
    .ready      (rsp_ready),
    .addr       (req_addr),
    .wdata      (req_wdata),
    .strb       (req_strb),
    .fetch      (req_fetch),
    .in_range   (in_range),
    .strb_ok    (strb_ok),
    .err_strobe (err_strobe),
    .err_hold   (err_hold),
    .err_range  (err_range)
  );

  bwr_word_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (word_idx[IW-1:0]),
    .wr_strb (req_strb),
    .wr_data (req_wdata),
    .rd_idx  (word_idx[IW-1:0]),
    .rd_data (store_rd)
  );

  always_comb begin
    fetch_d = handshake ? req_fetch : rsp_fetch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_fetch <= 1'b0;
    else        rsp_fetch <= fetch_d;
  end

  assert_ready_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> req_valid);
  assert_range_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_ready && !in_range) |=> err_range);
  assert_fetch_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_ready) |=> (rsp_fetch == $past(req_fetch)));

endmodule

// File: tb/tb_bus_word_responder.sv
`timescale 1ns/1ps
module tb_bus_word_responder;

  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        z_valid = 0, z_fetch = 0;
  logic [31:0] z_addr = 0, z_wdata = 0;
  logic [3:0]  z_strb = 0;
  logic        z_ready, z_fo, z_es, z_eh, z_er;
  logic [31:0] z_rdata;

  logic        w_valid = 0, w_fetch = 0;
  logic [31:0] w_addr = 0, w_wdata = 0;
  logic [3:0]  w_strb = 0;
  logic        w_ready, w_fo, w_es, w_eh, w_er;
  logic [31:0] w_rdata;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bus_word_responder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(z_valid), .req_addr(z_addr),
    .req_wdata(z_wdata), .req_strb(z_strb), .req_fetch(z_fetch),
    .rsp_ready(z_ready), .rsp_rdata(z_rdata), .rsp_fetch(z_fo),
    .err_strobe(z_es), .err_hold(z_eh), .err_range(z_er));

  bus_word_responder #(.WAIT_CYCLES(NW)) dut_wait (
    .clk(clk), .rst_n(rst_n), .req_valid(w_valid), .req_addr(w_addr),
    .req_wdata(w_wdata), .req_strb(w_strb), .req_fetch(w_fetch),
    .rsp_ready(w_ready), .rsp_rdata(w_rdata), .rsp_fetch(w_fo),
    .err_strobe(w_es), .err_hold(w_eh), .err_range(w_er));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic z_xfer(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                        input logic f, input logic [31:0] exp, input bit chk_rd, input string tag);
    @(negedge clk);
    z_valid = 1; z_addr = a; z_wdata = d; z_strb = s; z_fetch = f;
    #5;
    chk({tag, " ready"}, {31'b0, z_ready}, 32'd1);
    if (chk_rd) chk({tag, " rdata"}, z_rdata, exp);
  endtask

  task automatic z_idle();
    @(negedge clk);
    z_valid = 0; z_strb = 0; z_fetch = 0;
    #5;
  endtask

  task automatic t_reset_state();
    #5;
    chk("R1 ready in reset", {31'b0, z_ready}, 0);
    chk("R1 flags in reset", {27'b0, z_fo, z_es, z_eh, z_er, w_ready}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #5;
    chk("R1 after release", {26'b0, z_ready, z_fo, z_es, z_eh, z_er, w_ready}, 0);
  endtask

  task automatic t_lanes();
    z_xfer(32'h10, 32'h11223344, 4'b1111, 0, 0, 0, "R2 full write");
    z_idle();
    z_xfer(32'h10, 32'hDEAD0000, 4'b0000, 0, 32'h11223344, 1, "R4 read full");
    z_xfer(32'h10, 32'hAABBCCDD, 4'b0001, 0, 0, 0, "R4 byte0 write");
    z_xfer(32'h10, 32'h0, 4'b0000, 0, 32'h112233DD, 1, "R4 after byte0");
    z_xfer(32'h10, 32'h55667788, 4'b1100, 0, 0, 0, "R4 upper half");
    z_xfer(32'h10, 32'h0, 4'b0000, 0, 32'h556633DD, 1, "R4 after upper");
    z_xfer(32'h10, 32'h0000EE00, 4'b0010, 0, 0, 0, "R4 byte1 write");
    z_xfer(32'h10, 32'h0, 4'b0000, 0, 32'h5566EEDD, 1, "R4 after byte1");
    z_idle();
    chk("R2 no ready when idle", {31'b0, z_ready}, 0);
  endtask

  task automatic t_back_to_back();
    z_xfer(32'h20, 32'h01020304, 4'b1111, 0, 0, 0, "R11 write a");
    z_xfer(32'h24, 32'hA0B0C0D0, 4'b1111, 0, 0, 0, "R11 write b");
    z_xfer(32'h20, 32'hFFFFFFFF, 4'b0000, 0, 32'h01020304, 1, "R11 read a");
    z_xfer(32'h24, 32'hFFFFFFFF, 4'b0000, 0, 32'hA0B0C0D0, 1, "R11 read b");
    z_xfer(32'h20, 32'h0, 4'b0000, 0, 32'h01020304, 1, "R5 read leaves word");
    z_idle();
  endtask

  task automatic t_fetch();
    z_xfer(32'h24, 0, 4'b0000, 1, 32'hA0B0C0D0, 1, "R10 fetch read");
    z_idle();
    chk("R10 fetch recorded", {31'b0, z_fo}, 1);
    z_xfer(32'h24, 0, 4'b0000, 0, 32'hA0B0C0D0, 1, "R10 data read");
    z_idle();
    chk("R10 fetch cleared", {31'b0, z_fo}, 0);
  endtask

  task automatic t_bad_strobe();
    chk("R6 clean before", {31'b0, z_es}, 0);
    z_xfer(32'h10, 32'hFFFFFFFF, 4'b0101, 0, 0, 0, "R6 illegal 0101");
    z_idle();
    chk("R6 flag set", {31'b0, z_es}, 1);
    z_xfer(32'h10, 32'hFFFFFFFF, 4'b0110, 0, 0, 0, "R6 illegal 0110");
    z_xfer(32'h10, 0, 4'b0000, 0, 32'h5566EEDD, 1, "R6 memory kept");
    z_idle();
  endtask

  task automatic t_range();
    chk("R8 clean before", {31'b0, z_er}, 0);
    z_xfer(32'h400, 32'h12345678, 4'b1111, 0, 0, 0, "R8 far write");
    z_idle();
    chk("R8 flag set", {31'b0, z_er}, 1);
    z_xfer(32'h400, 0, 4'b0000, 0, 32'h0, 1, "R8 far read zero");
    z_xfer(32'h0, 32'h0BADF00D, 4'b1111, 0, 0, 0, "R8 alias write");
    z_xfer(32'h400, 0, 4'b0000, 0, 32'h0, 1, "R8 no alias");
    z_idle();
  endtask

  task automatic t_sticky();
    z_xfer(32'h20, 0, 4'b0000, 0, 32'h01020304, 1, "R9 clean read");
    z_idle();
    chk("R9 flags stay", {29'b0, z_es, z_eh, z_er}, 32'h5);
  endtask

  task automatic w_xfer(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                        input logic [31:0] exp, input bit chk_rd, input string tag);
    @(negedge clk);
    w_valid = 1; w_addr = a; w_wdata = d; w_strb = s;
    for (int c = 0; c <= NW; c++) begin
      #5;
      chk({tag, " R3 ready timing"}, {31'b0, w_ready}, (c == NW) ? 1 : 0);
      if (c == NW && chk_rd) chk({tag, " rdata"}, w_rdata, exp);
      if (c < NW) @(negedge clk);
    end
    @(negedge clk);
    w_valid = 0; w_strb = 0;
    #5;
    chk({tag, " R3 ready one cycle"}, {31'b0, w_ready}, 0);
  endtask

  task automatic t_wait();
    w_xfer(32'h40, 32'hCAFEF00D, 4'b1111, 0, 0, "wait write");
    w_xfer(32'h40, 32'h0, 4'b0000, 32'hCAFEF00D, 1, "wait read");
    chk("R7 clean transfers", {31'b0, w_eh}, 0);
  endtask

  task automatic t_hold_change();
    @(negedge clk);
    w_valid = 1; w_addr = 32'h40; w_strb = 0;
    @(negedge clk);
    w_addr = 32'h44;
    #5;
    chk("R7 not yet flagged", {31'b0, w_eh}, 0);
    @(negedge clk);
    #5;
    chk("R7 change flagged", {31'b0, w_eh}, 1);
    @(negedge clk);
    @(negedge clk);
    w_valid = 0;
    #5;
  endtask

  task automatic t_hold_withdraw();
    @(negedge clk);
    rst_n = 0;
    #5;
    chk("R9 reset clears", {28'b0, z_es, z_er, w_eh, w_es}, 0);
    @(negedge clk);
    rst_n = 1;
    w_valid = 1; w_addr = 32'h40; w_strb = 0;
    @(negedge clk);
    w_valid = 0;
    #5;
    chk("R7 not yet flagged on withdraw", {31'b0, w_eh}, 0);
    @(negedge clk);
    #5;
    chk("R7 withdraw flagged", {31'b0, w_eh}, 1);
  endtask

  initial begin
    t_reset_state();
    t_lanes();
    t_back_to_back();
    t_fetch();
    t_bad_strobe();
    t_range();
    t_sticky();
    t_wait();
    t_hold_change();
    t_hold_withdraw();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule